// File: doc/BRIEF.md
# Byte-Parity Protected Data SRAM

This block is a 16 KB single-port data memory that sits on a 32-bit system bus at byte address 0x2000_0000. A bus master reads and writes it one aligned word at a time. Four byte-lane strobes choose the lanes, so byte, half-word and word accesses all use the same path. Read data comes back one cycle after the address phase.

Each stored byte has an even-parity bit. The bit is recomputed for every lane that a write touches, and this happens whether or not checking is switched on. A static configuration input turns checking on. While it is on, each read compares the stored parity of the lanes it asked for against the data that comes back. A mismatch on any requested lane gives a one-cycle non-maskable interrupt request and sets a sticky error flag. Software clears the flag by writing 1 to it, which reaches the block as a clear pulse.

A test-only port can invert one stored parity bit, so that detection can be checked without touching the data.

Top module: `parity_sram`

## Requirements
- R1: A read inside the window returns on `rdData`, one cycle after its address phase, the 32-bit word last written at that aligned address. Bits [1:0] of the address are ignored. The last word, 0x2000_3FFC, works like any other. In a cycle that does not follow a read, `rdData` is zero.
- R2: A write updates only the byte lanes whose `reqStrb` bit is set. `reqStrb[i]` selects data bits [8i+7:8i]. The other lanes of the word keep their previous contents.
- R3: A read outside 0x2000_0000 to 0x2000_3FFF returns zero and raises no error. A write outside that range changes no stored byte.
- R4: Each written lane stores an even-parity bit (the XOR of its eight data bits) whether `parityEn` is high or low. Turning checking on later therefore reports no error for data written while it was off.
- R5: A read checks only the lanes whose `reqStrb` bit is set. A corrupted lane that was not requested causes no error.
- R6: While `parityEn` is low, no read raises `nmiReq` or sets `errFlag`, even on a corrupted lane.
- R7: A read with checking enabled and a parity mismatch on a requested lane drives `nmiReq` high for exactly the one cycle in which its data is returned. Each such read gives its own pulse.
- R8: `errFlag` goes high the cycle after an `nmiReq` pulse and stays high until `errClr` is pulsed. If a new error and a clear arrive in the same cycle, the flag stays set.
- R9: A `tbFlipValid` pulse inverts the stored parity bit of word `tbFlipIdx`, lane `tbFlipLane`. A later write to that lane stores fresh parity and removes the corruption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request in this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 32 | Byte address of the access |
| reqStrb | input | 4 | Byte-lane select for writes and reads |
| reqWdata | input | 32 | Write data |
| rdData | output | 32 | Read data, valid the cycle after a read |
| parityEn | input | 1 | Static enable for parity checking |
| errClr | input | 1 | Write-1-to-clear pulse for the error flag |
| errFlag | output | 1 | Sticky parity error flag |
| nmiReq | output | 1 | Non-maskable interrupt request pulse |
| tbFlipValid | input | 1 | Test backdoor: invert one parity bit |
| tbFlipIdx | input | 12 | Test backdoor word index |
| tbFlipLane | input | 2 | Test backdoor byte lane |

## Verification
Random strobe-mixed writes and reads over a small set of words are checked against a bench model. These catch lane mix-ups and a read path that is off by one cycle. Directed cases then corrupt a lane and:
- read it with and without that lane in the strobes, which catches a checker that ignores the strobes;
- read it with checking off, which catches a checker that ignores the enable;
- rewrite only a neighbouring lane, which catches parity regenerated for the whole word;
- rewrite the lane itself, which catches parity that is never refreshed.

Further directed reads and writes probe both window edges, which catches aliasing or a missing range check. A failing read is also issued together with a clear, which catches a clear that wins over a new error.

// File: rtl/psram_pkg.sv
package psram_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int DATA_W = LANES * BYTE_W;

  // Strobes from control to datapath for one access cycle.
  typedef struct packed {
    logic             rdEn;
    logic [LANES-1:0] wrLanes;
  } memStrb_t;
endpackage

// File: rtl/psram_ctrl.sv
module psram_ctrl
  import psram_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR  = 32'h2000_0000,
  parameter int          SIZE_BYTES = 16384,
  parameter int          IDX_W      = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [31:0]      reqAddr,
  input  logic [LANES-1:0] reqStrb,
  input  logic             parityEn,
  input  logic             errClr,
  input  logic [LANES-1:0] laneMismatch,
  output memStrb_t         memStrb,
  output logic [IDX_W-1:0] wordIdx,
  output logic             hitQ,
  output logic             errFlag,
  output logic             nmiReq
);
  localparam logic [31:0] SIZE32 = 32'(SIZE_BYTES);

  logic [31:0]      offset;
  logic             inWin;
  logic [LANES-1:0] chkQ;
  logic             failNow;
  logic             flagQ;

  assign offset  = reqAddr - BASE_ADDR;
  assign inWin   = offset < SIZE32;
  assign wordIdx = offset[IDX_W+1:2];

  always_comb begin
    memStrb.rdEn    = reqValid && !reqWrite && inWin;
    memStrb.wrLanes = (reqValid && reqWrite && inWin) ? reqStrb : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitQ <= 1'b0;
      chkQ <= '0;
    end else begin
      hitQ <= memStrb.rdEn;
      chkQ <= (memStrb.rdEn && parityEn) ? reqStrb : '0;
    end
  end

  assign failNow = |(laneMismatch & chkQ);
  assign nmiReq  = failNow;

  always_ff @(posedge clk) begin
    if (!rstN)        flagQ <= 1'b0;
    else if (failNow) flagQ <= 1'b1;
    else if (errClr)  flagQ <= 1'b0;
  end

  assign errFlag = flagQ;
endmodule

// File: rtl/psram_datapath.sv
module psram_datapath
  import psram_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int IDX_W = 12
) (
  input  logic              clk,
  input  memStrb_t          memStrb,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic              flipValid,
  input  logic [IDX_W-1:0]  flipIdx,
  input  logic [1:0]        flipLane,
  output logic [DATA_W-1:0] rdWord,
  output logic [LANES-1:0]  laneMismatch
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] byteMem [DEPTH];
    logic              parMem  [DEPTH];
    logic [BYTE_W-1:0] byteQ;
    logic              parQ;
    logic [BYTE_W-1:0] wrByte;

    assign wrByte = wrData[g*BYTE_W +: BYTE_W];

    always_ff @(posedge clk) begin
      if (memStrb.wrLanes[g]) begin
        byteMem[wordIdx] <= wrByte;
        parMem[wordIdx]  <= ^wrByte;
      end else if (flipValid && flipLane == 2'(g)) begin
        parMem[flipIdx] <= ~parMem[flipIdx];
      end
      if (memStrb.rdEn) begin
        byteQ <= byteMem[wordIdx];
        parQ  <= parMem[wordIdx];
      end
    end

    assign rdWord[g*BYTE_W +: BYTE_W] = byteQ;
    assign laneMismatch[g]            = (^byteQ) != parQ;
  end
endmodule

// File: rtl/parity_sram.sv
module parity_sram
  import psram_pkg::*;
#(
  parameter logic [31:0] BASE_ADDR  = 32'h2000_0000,
  parameter int          SIZE_BYTES = 16384,
  parameter int          IDX_W      = $clog2(SIZE_BYTES / 4)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [31:0]      reqAddr,
  input  logic [3:0]       reqStrb,
  input  logic [31:0]      reqWdata,
  output logic [31:0]      rdData,
  input  logic             parityEn,
  input  logic             errClr,
  output logic             errFlag,
  output logic             nmiReq,
  input  logic             tbFlipValid,
  input  logic [IDX_W-1:0] tbFlipIdx,
  input  logic [1:0]       tbFlipLane
);
  localparam int DEPTH = SIZE_BYTES / 4;

  memStrb_t         memStrb;
  logic [IDX_W-1:0] wordIdx;
  logic             hitQ;
  logic [31:0]      rawWord;
  logic [LANES-1:0] laneMismatch;

  psram_ctrl #(.BASE_ADDR(BASE_ADDR), .SIZE_BYTES(SIZE_BYTES), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqStrb(reqStrb), .parityEn(parityEn), .errClr(errClr),
    .laneMismatch(laneMismatch), .memStrb(memStrb), .wordIdx(wordIdx),
    .hitQ(hitQ), .errFlag(errFlag), .nmiReq(nmiReq)
  );

  psram_datapath #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .memStrb(memStrb), .wordIdx(wordIdx), .wrData(reqWdata),
    .flipValid(tbFlipValid), .flipIdx(tbFlipIdx), .flipLane(tbFlipLane),
    .rdWord(rawWord), .laneMismatch(laneMismatch)
  );

  assign rdData = hitQ ? rawWord : '0;
endmodule

// File: rtl/parity_sram_chk.sv
module parity_sram_chk #(
  parameter logic [31:0] BASE_ADDR  = 32'h2000_0000,
  parameter int          SIZE_BYTES = 16384
) (
  input logic        clk,
  input logic        rstN,
  input logic        reqValid,
  input logic        reqWrite,
  input logic [31:0] reqAddr,
  input logic [31:0] rdData,
  input logic        parityEn,
  input logic        errClr,
  input logic        errFlag,
  input logic        nmiReq
);
  logic isRead;
  logic outside;
  assign isRead  = reqValid && !reqWrite;
  assign outside = (reqAddr < BASE_ADDR) || (reqAddr >= BASE_ADDR + 32'(SIZE_BYTES));

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !isRead |=> rdData == '0);
  // R3
  outside_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isRead && outside) |=> (rdData == '0 && !nmiReq));
  // R6
  nmi_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |-> parityEn);
  // R7
  nmi_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |-> $past(isRead));
  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    nmiReq |=> errFlag);
  // R8
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !errClr) |=> errFlag);
  // R8
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errClr && !nmiReq) |=> !errFlag);
  // R8
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> $past(nmiReq));
endmodule

bind parity_sram parity_sram_chk #(.BASE_ADDR(BASE_ADDR), .SIZE_BYTES(SIZE_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .rdData(rdData), .parityEn(parityEn), .errClr(errClr),
  .errFlag(errFlag), .nmiReq(nmiReq)
);

// File: tb/tb_parity_sram.sv
module tb_parity_sram;
  localparam logic [31:0] BASE = 32'h2000_0000;
  localparam int DEPTH = 4096;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqAddr = '0, reqWdata = '0;
  logic [3:0]  reqStrb = '0;
  logic [31:0] rdData;
  logic        parityEn = 1'b1, errClr = 1'b0;
  logic        errFlag, nmiReq;
  logic        tbFlipValid = 1'b0;
  logic [11:0] tbFlipIdx = '0;
  logic [1:0]  tbFlipLane = '0;

  int checks = 0, errors = 0;
  logic [31:0] refMem [DEPTH];
  logic [3:0]  refBad [DEPTH];
  logic        refFlag = 1'b0;
  bit          done = 0;

  always #5 clk = ~clk;

  parity_sram dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqStrb(reqStrb), .reqWdata(reqWdata), .rdData(rdData),
    .parityEn(parityEn), .errClr(errClr), .errFlag(errFlag), .nmiReq(nmiReq),
    .tbFlipValid(tbFlipValid), .tbFlipIdx(tbFlipIdx), .tbFlipLane(tbFlipLane)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mergeLanes(input logic [31:0] old, input logic [31:0] nw,
                                             input logic [3:0] strb);
    logic [31:0] r = old;
    for (int i = 0; i < 4; i++) if (strb[i]) r[i*8 +: 8] = nw[i*8 +: 8];
    return r;
  endfunction

  function automatic logic expErr(input int idx, input logic [3:0] strb);
    return parityEn && |(strb & refBad[idx]);
  endfunction

  task automatic doWrite(input logic [31:0] addr, input logic [3:0] strb, input logic [31:0] data);
    logic [31:0] off = addr - BASE;
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = addr; reqStrb = strb; reqWdata = data;
    @(negedge clk);
    reqValid = 0; reqWrite = 0;
    if (off < 32'(DEPTH * 4)) begin
      refMem[off[13:2]] = mergeLanes(refMem[off[13:2]], data, strb);
      refBad[off[13:2]] = refBad[off[13:2]] & ~strb;
    end
  endtask

  // Read; check data and nmi in return cycle, then errFlag one cycle later.
  task automatic doRead(input string req, input logic [31:0] addr, input logic [3:0] strb,
                        input logic clrWithData);
    logic [31:0] off = addr - BASE;
    logic inWin = off < 32'(DEPTH * 4);
    logic e = inWin ? expErr(int'(off[13:2]), strb) : 1'b0;
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = addr; reqStrb = strb;
    @(negedge clk);
    reqValid = 0;
    errClr = clrWithData;
    check(req, rdData, inWin ? refMem[off[13:2]] : 32'h0);
    check(req, {31'b0, nmiReq}, {31'b0, e});
    if (e) refFlag = 1'b1; else if (clrWithData) refFlag = 1'b0;
    @(negedge clk);
    errClr = 0;
    check(req, {31'b0, nmiReq}, 32'h0);
    check(req, {31'b0, errFlag}, {31'b0, refFlag});
  endtask

  task automatic flip(input int idx, input int lane);
    @(negedge clk);
    tbFlipValid = 1; tbFlipIdx = 12'(idx); tbFlipLane = 2'(lane);
    @(negedge clk);
    tbFlipValid = 0;
    refBad[idx][lane] = ~refBad[idx][lane];
  endtask

  task automatic clearFlag(input string req);
    @(negedge clk); errClr = 1;
    @(negedge clk); errClr = 0;
    refFlag = 1'b0;
    check(req, {31'b0, errFlag}, 32'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < DEPTH; i++) begin refMem[i] = '0; refBad[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 reset rdData", rdData, 32'h0);
    check("R8 reset errFlag", {31'b0, errFlag}, 32'h0);
    check("R7 reset nmiReq", {31'b0, nmiReq}, 32'h0);

    // Fill a working set and the top word.
    for (int i = 0; i < 64; i++) doWrite(BASE + 32'(i * 4), 4'hF, $urandom);
    doWrite(BASE + 32'h3FFC, 4'hF, 32'hA5C3_0F1E);

    // R1 R2 random mixed-strobe traffic
    for (int n = 0; n < 400; n++) begin
      int idx = int'($urandom_range(0, 63));
      logic [3:0] s = 4'($urandom_range(1, 15));
      logic [31:0] a = BASE + 32'(idx * 4) + 32'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 1) doWrite(a, s, $urandom);
      else doRead("R1 R2 random", a, s, 1'b0);
    end
    doRead("R1 top word", BASE + 32'h3FFC, 4'hF, 1'b0);
    doWrite(BASE + 32'h10, 4'b0100, 32'h00AB_0000);
    doRead("R2 single lane", BASE + 32'h10, 4'hF, 1'b0);

    // R3 window edges
    doWrite(BASE + 32'h4000, 4'hF, 32'hDEAD_BEEF);
    doRead("R3 above window", BASE + 32'h4000, 4'hF, 1'b0);
    doRead("R3 no alias", BASE, 4'hF, 1'b0);
    doWrite(BASE - 32'h4, 4'hF, 32'h1234_5678);
    doRead("R3 below window", BASE - 32'h4, 4'hF, 1'b0);
    doRead("R3 top word intact", BASE + 32'h3FFC, 4'hF, 1'b0);

    // R9 R5 R7 R8: corrupt lane 2 of word 5
    flip(5, 2);
    doRead("R5 unrequested lane", BASE + 32'h14, 4'b0011, 1'b0);
    doRead("R7 R9 detected", BASE + 32'h14, 4'b0100, 1'b0);
    doRead("R7 second pulse", BASE + 32'h14, 4'b1100, 1'b0);
    doRead("R8 sticky", BASE + 32'h14, 4'b0001, 1'b0);
    clearFlag("R8 clear");
    doRead("R8 set wins over clear", BASE + 32'h14, 4'b0100, 1'b1);
    clearFlag("R8 clear again");

    // R6 checking disabled
    parityEn = 0;
    doRead("R6 disabled", BASE + 32'h14, 4'hF, 1'b0);
    // R4 write with checking off, then enable
    doWrite(BASE + 32'h20, 4'hF, 32'h8001_7F03);
    parityEn = 1;
    doRead("R4 no false error", BASE + 32'h20, 4'hF, 1'b0);

    // R9 rewrite neighbouring lane keeps corruption, rewrite lane heals
    doWrite(BASE + 32'h14, 4'b1000, 32'h7700_0000);
    doRead("R9 neighbour write", BASE + 32'h14, 4'b0100, 1'b0);
    clearFlag("R8 clear 3");
    doWrite(BASE + 32'h14, 4'b0100, 32'h0055_0000);
    doRead("R9 rewrite heals", BASE + 32'h14, 4'hF, 1'b0);

    // R5 half-word read ignores corrupted lane 0 of word 9
    flip(9, 0);
    doRead("R5 upper half", BASE + 32'h24, 4'b1100, 1'b0);
    doRead("R7 lower half", BASE + 32'h24, 4'b0011, 1'b0);
    clearFlag("R8 clear 4");
    // R3 outside reads never error
    doRead("R3 outside no error", BASE + 32'h4024, 4'hF, 1'b0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule